// File: doc/BRIEF.md
# Delay-Loop Lock Sequencer

This block decides when a delay-locked clock path may be treated as locked, so that memory traffic can be held off until the loop has settled. It runs a counter on the incoming data clock and reports lock once that clock has been seen stable for `LOCK_CYCLES` consecutive edges (1024 by default). It does not model the delay line or any phase comparison. It is only the cycle-accurate sequencer that reports whether lock may be assumed.

A second, free-running reference clock watches the data clock for stalls. Each data-clock edge flips a toggle. The reference domain counts its own ticks since it last saw that toggle change. When the count reaches the equivalent of `STALL_PS` (30 ns by default), the reference domain flips a stall toggle once. When the data clock runs again, the stall toggle reaches the data-clock domain through a synchroniser. The lock counter then clears and acquisition restarts by itself, with no reset required. A clock that is slower than the stall window therefore never locks; the loop's valid range starts at 80 MHz.

A level strap turns the mechanism on or off. With the strap low the block reports bypass, holds the count at zero and never reports lock. When the strap is raised again, acquisition starts from zero.

Top module: `dll_lock_seq`

## Requirements
- R1: While `rst_n` is low, `lock_o`=0, `bypass_o`=0 and `count_o`=0. They still hold these values after the second data-clock rising edge that follows release.
- R2: With `lock_en`=1, the first edge that counts is the third data-clock rising edge after reset release. `count_o` then rises by exactly one per edge, so `count_o`=1023 with `lock_o`=0 after edge 1025, and `lock_o`=1 with `count_o`=1024 after edge 1026.
- R3: `count_o` never exceeds `LOCK_CYCLES`. Once it reaches that value it holds, and `lock_o` stays high while the data clock keeps running.
- R4: A data-clock gap of at least `STALL_PS` plus two reference periods clears the state on the third data-clock edge after the clock resumes (`lock_o`=0, `count_o`=0). Lock returns 1024 edges after that clearing edge.
- R5: A data-clock gap no longer than `STALL_PS` minus two reference periods leaves `lock_o` and `count_o` unchanged.
- R6: A data clock whose period exceeds the stall window never produces `lock_o`=1.
- R7: On the third data-clock edge after `lock_en` falls, `bypass_o` becomes 1 while `lock_o` and `count_o` go to 0. They stay there while the strap is low.
- R8: On the third data-clock edge after `lock_en` rises, `bypass_o` returns to 0 and `count_o`=1. Lock follows 1023 edges later, with no reset.
- R9: Whenever `lock_o`=1, `count_o` equals `LOCK_CYCLES`. Whenever `lock_o` falls, `count_o` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock used to time stalls |
| in_clk | input | 1 | Data clock whose stability is being tracked |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each domain |
| lock_en | input | 1 | Static strap: 1 enables lock tracking, 0 selects bypass |
| lock_o | output | 1 | Lock may be assumed (data-clock domain) |
| bypass_o | output | 1 | Strap is low and the loop is bypassed (data-clock domain) |
| count_o | output | clog2(LOCK_CYCLES+1) | Stable-edge count, saturating at LOCK_CYCLES |

## Verification
Every result lands on a fixed data-clock edge, counted from the stimulus:
- After reset release, the first count happens on edge 3 and lock is reported on edge 1026.
- After a strap change, the outputs move on edge 3 following the change.
- After a long stall, the clear lands on edge 3 after the clock resumes, and relock comes 1024 edges later.

The driver numbers every rising edge it generates and queues each expectation against an exact edge index. The monitor samples on the following falling edge, so the edges just before and just after each transition are both checked. Stall timing depends on where reference ticks fall relative to data-clock edges, so the test gaps stay well clear of the window on both sides. The slow-clock case checks only the lock flag, because the count there varies from edge to edge.

// File: rtl/dll_seq_pkg.sv
`timescale 1ns/1ps
package dll_seq_pkg;

  // Round-up division used to turn a time window into reference ticks.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  typedef enum logic [1:0] {
    LK_ACQUIRE = 2'd0,
    LK_LOCKED  = 2'd1,
    LK_BYPASS  = 2'd2
  } lk_state_e;

endpackage

// File: rtl/dll_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchroniser with a selectable reset value.
module dll_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dll_stall_mon.sv
`timescale 1ns/1ps
// Reference-domain watchdog: flips stall_tgl once per data-clock silence
// lasting STALL_TICKS reference cycles.
module dll_stall_mon #(
  parameter int STALL_TICKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_tgl_async,
  output logic stall_tgl
);

  localparam int SW = $clog2(STALL_TICKS + 1);
  localparam logic [SW-1:0] LIMIT  = SW'(STALL_TICKS);
  localparam logic [SW-1:0] FIRE_AT = SW'(STALL_TICKS - 1);

  logic          tg_s, tg_d;
  logic          seen_edge;
  logic [SW-1:0] quiet_q, quiet_n;
  logic          stall_q, stall_n;
  logic          fire;

  dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tg_sync (
    .clk(clk), .rst_n(rst_n), .d(edge_tgl_async), .q(tg_s)
  );

  assign seen_edge = tg_s ^ tg_d;
  assign fire      = !seen_edge && (quiet_q == FIRE_AT);

  always_comb begin
    quiet_n = quiet_q;
    stall_n = stall_q;
    if (seen_edge) begin
      quiet_n = '0;
    end else if (quiet_q != LIMIT) begin
      quiet_n = quiet_q + SW'(1);
    end
    if (fire) stall_n = ~stall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tg_d    <= 1'b0;
      quiet_q <= '0;
      stall_q <= 1'b0;
    end else begin
      tg_d    <= tg_s;
      quiet_q <= quiet_n;
      stall_q <= stall_n;
    end
  end

  assign stall_tgl = stall_q;

endmodule

// File: rtl/dll_lock_ctr.sv
`timescale 1ns/1ps
// Data-clock domain: stable-edge counter, restart on stall, strap bypass.
module dll_lock_ctr
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  logic          stall_tgl_async,
  output logic          edge_tgl,
  output logic          lock_o,
  output logic          bypass_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

  logic          en_s, st_s, st_d, restart;
  logic          tog_q;
  logic [CW-1:0] cnt_q, cnt_n;
  lk_state_e     state_q, state_n;

  dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en_async), .q(en_s)
  );

  dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_st_sync (
    .clk(clk), .rst_n(rst_n), .d(stall_tgl_async), .q(st_s)
  );

  assign restart = st_s ^ st_d;

  always_comb begin
    cnt_n   = cnt_q;
    state_n = state_q;
    if (!en_s) begin
      cnt_n   = '0;
      state_n = LK_BYPASS;
    end else if (restart) begin
      cnt_n   = '0;
      state_n = LK_ACQUIRE;
    end else if (cnt_q != FULL) begin
      cnt_n   = cnt_q + CW'(1);
      state_n = (cnt_n == FULL) ? LK_LOCKED : LK_ACQUIRE;
    end else begin
      state_n = LK_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      st_d    <= 1'b0;
      cnt_q   <= '0;
      state_q <= LK_ACQUIRE;
    end else begin
      tog_q   <= ~tog_q;
      st_d    <= st_s;
      cnt_q   <= cnt_n;
      state_q <= state_n;
    end
  end

  assign edge_tgl = tog_q;
  assign lock_o   = (state_q == LK_LOCKED);
  assign bypass_o = (state_q == LK_BYPASS);
  assign count_o  = cnt_q;

endmodule

// File: rtl/dll_lock_seq.sv
`timescale 1ns/1ps
// Top: lock-wait and restart sequencer for a delay-locked clock path.
module dll_lock_seq #(
  parameter int LOCK_CYCLES   = 1024,
  parameter int REF_PERIOD_PS = 8000,
  parameter int STALL_PS      = 30000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                               ref_clk,
  input  logic                               in_clk,
  input  logic                               rst_n,
  input  logic                               lock_en,
  output logic                               lock_o,
  output logic                               bypass_o,
  output logic [$clog2(LOCK_CYCLES+1)-1:0]   count_o
);

  localparam int STALL_TICKS = dll_seq_pkg::ceil_div(STALL_PS, REF_PERIOD_PS);

  logic rst_ref_n, rst_in_n;
  logic edge_tgl, stall_tgl;

  // Asynchronous assert, synchronous release in each domain.
  dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_ref (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(rst_ref_n)
  );

  dll_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_in (
    .clk(in_clk), .rst_n(rst_n), .d(1'b1), .q(rst_in_n)
  );

  dll_stall_mon #(
    .STALL_TICKS(STALL_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_stall (
    .clk(ref_clk),
    .rst_n(rst_ref_n),
    .edge_tgl_async(edge_tgl),
    .stall_tgl(stall_tgl)
  );

  dll_lock_ctr #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctr (
    .clk(in_clk),
    .rst_n(rst_in_n),
    .en_async(lock_en),
    .stall_tgl_async(stall_tgl),
    .edge_tgl(edge_tgl),
    .lock_o(lock_o),
    .bypass_o(bypass_o),
    .count_o(count_o)
  );

endmodule

// File: rtl/dll_lock_seq_chk.sv
`timescale 1ns/1ps
module dll_lock_seq_chk #(
  parameter int LOCK_CYCLES = 1024,
  localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
  input logic          in_clk,
  input logic          rst_n,
  input logic          lock_o,
  input logic          bypass_o,
  input logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

  // R2: the count moves only by one step or by clearing
  a_r2_count_steps: assert property (@(posedge in_clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |->
      (count_o == CW'($past(count_o) + 1'b1) || count_o == '0));

  // R3: the count never passes the lock value
  a_r3_no_overflow: assert property (@(posedge in_clk) disable iff (!rst_n)
    count_o <= FULL);

  // R9: lock implies a full count
  a_r9_lock_full: assert property (@(posedge in_clk) disable iff (!rst_n)
    lock_o |-> (count_o == FULL));

  // R9 / R4: dropping lock goes with a cleared count
  a_r4_drop_clears: assert property (@(posedge in_clk) disable iff (!rst_n)
    $fell(lock_o) |-> (count_o == '0));

  // R7: bypass keeps lock low and count at zero
  a_r7_bypass_idle: assert property (@(posedge in_clk) disable iff (!rst_n)
    bypass_o |-> (!lock_o && count_o == '0));

endmodule

bind dll_lock_seq dll_lock_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .in_clk(in_clk),
  .rst_n(rst_n),
  .lock_o(lock_o),
  .bypass_o(bypass_o),
  .count_o(count_o)
);

// File: tb/sim_dll_lock_seq.sv
`timescale 1ns/1ps
module sim_dll_lock_seq;

  localparam int LOCKN = 1024;
  localparam int CW = $clog2(LOCKN + 1);

  logic ref_clk = 1'b0;
  logic in_clk  = 1'b0;
  logic rst_n   = 1'b0;
  logic lock_en = 1'b1;
  logic lock_o, bypass_o;
  logic [CW-1:0] count_o;

  int errors = 0;
  int checks = 0;
  int kedge  = 0;
  int refcyc = 0;
  bit done   = 1'b0;

  typedef struct {
    int    edge_no;
    bit    lk;
    bit    bp;
    int    cnt;
    bit    use_cnt;
    string tag;
  } exp_t;

  exp_t q[$];

  dll_lock_seq #(.LOCK_CYCLES(LOCKN)) u0 (
    .ref_clk(ref_clk), .in_clk(in_clk), .rst_n(rst_n), .lock_en(lock_en),
    .lock_o(lock_o), .bypass_o(bypass_o), .count_o(count_o)
  );

  always #4 ref_clk = ~ref_clk;  // 125 MHz

  task automatic report(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int e, input bit lk, input bit bp, input int cnt,
                      input bit use_cnt, input string tag);
    exp_t it;
    it.edge_no = e; it.lk = lk; it.bp = bp; it.cnt = cnt;
    it.use_cnt = use_cnt; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic kcycle(input int hi, input int lo);
    in_clk = 1'b1;
    if (rst_n) kedge++;
    #(hi);
    in_clk = 1'b0;
    #(lo);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) kcycle(5, 5);
  endtask

  // Monitor: pops expectations due on the edge just taken
  always @(negedge in_clk) begin
    exp_t it;
    if (rst_n) begin
      while (q.size() > 0 && q[0].edge_no <= kedge) begin
        it = q.pop_front();
        if (it.edge_no < kedge) begin
          report({it.tag, " missed edge"}, 1'b0, kedge, it.edge_no);
        end else begin
          report({it.tag, " lock"},   lock_o == it.lk,   int'(lock_o),   int'(it.lk));
          report({it.tag, " bypass"}, bypass_o == it.bp, int'(bypass_o), int'(it.bp));
          if (it.use_cnt)
            report({it.tag, " count"}, int'(count_o) == it.cnt, int'(count_o), it.cnt);
        end
      end
    end
  end

  // Watchdog
  always @(posedge ref_clk) begin
    refcyc++;
    if (refcyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", refcyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b;
    // R1: reset state
    run(5);
    report("R1 reset lock",   lock_o == 1'b0,   int'(lock_o), 0);
    report("R1 reset bypass", bypass_o == 1'b0, int'(bypass_o), 0);
    report("R1 reset count",  count_o == '0,    int'(count_o), 0);
    rst_n = 1'b1;

    // R1, R2, R3: initial acquisition
    push(2,    0, 0, 0,    1, "R1 post-release");
    push(1025, 0, 0, 1023, 1, "R2 one before lock");
    push(1026, 1, 0, 1024, 1, "R2 lock edge");
    push(1200, 1, 0, 1024, 1, "R3 saturated");
    run(1200);

    // R5: short gaps keep lock
    b = kedge;
    push(b + 40, 1, 0, 1024, 1, "R5 short gaps");
    push(b + 44, 1, 0, 1024, 1, "R5 after gaps");
    for (int i = 0; i < 20; i++) begin
      kcycle(5, 10);
      kcycle(5, 5);
    end
    run(4);

    // R4: long stall, restart, relock
    b = kedge + 1;
    push(b + 2,    1, 0, 1024, 1, "R4 before clear");
    push(b + 3,    0, 0, 0,    1, "R4 clear");
    push(b + 1026, 0, 0, 1023, 1, "R4 one before relock");
    push(b + 1027, 1, 0, 1024, 1, "R4 relock");
    kcycle(5, 105);
    run(1030);

    // R7: strap low selects bypass
    b = kedge;
    lock_en = 1'b0;
    push(b + 2,   1, 0, 1024, 1, "R7 before bypass");
    push(b + 3,   0, 1, 0,    1, "R7 bypass entry");
    push(b + 300, 0, 1, 0,    1, "R7 bypass held");
    run(300);

    // R8: strap high restarts without reset
    b = kedge;
    lock_en = 1'b1;
    push(b + 2,    0, 1, 0,    1, "R8 before exit");
    push(b + 3,    0, 0, 1,    1, "R8 exit");
    push(b + 1025, 0, 0, 1023, 1, "R8 one before lock");
    push(b + 1026, 1, 0, 1024, 1, "R8 lock");
    run(1030);

    // R6: clock slower than the stall window never locks
    b = kedge;
    push(b + 10, 0, 0, 0, 0, "R6 slow a");
    push(b + 20, 0, 0, 0, 0, "R6 slow b");
    push(b + 40, 0, 0, 0, 0, "R6 slow c");
    for (int i = 0; i < 40; i++) kcycle(30, 30);
    run(3);

    report("queue drained", q.size() == 0, q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule